// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block issues the complete bus cycle sequence for writing one NAND page when the data arrives as several separate pieces. Each piece (a chunk) has a column offset, a flag selecting the main or the spare area, and a word count. Chunk descriptors and data bytes are loaded into two small internal queues. A start pulse then begins the sequence. The block drives the command-latch, address-latch, write and read strobes, emitting at most one strobe per clock. Each strobe has its byte on an 8-bit bus. Chip enable is asserted for the whole operation.

The first chunk opens the page with the load command and a full five-cycle address. Every later chunk changes only the column, using the random-input command. The confirm command is sent once at the end. The block then waits for the ready/busy line to go low and come back high. It issues a status read and decodes the returned byte into a pass or fail result. In copy mode the block first loads a source page with the copy-read command and waits for ready. It then opens the destination page with a full address, and every chunk after that is inserted as a column-only patch. If the data queue runs dry in the middle of a chunk, the block holds its position without strobing.

Top module: `nand_prog_seq`

## Requirements
- R1: After reset, chip enable, all four strobes, busy and done are low.
- R2: In program mode the first chunk produces command 0x80 followed by five address cycles, in this order: column low byte, column high byte, then row bits 7:0, 15:8 and 23:16.
- R3: The column sent for a chunk is its offset for the main area, and its offset plus 2048 (PAGE_MAIN) for the spare area.
- R4: Every chunk other than the first program-mode chunk produces command 0x85 followed by two address cycles: column low byte, then column high byte.
- R5: After a chunk's address cycles, exactly its length count of write strobes follows, carrying the data bytes in the order they were pushed. A zero length gives no write strobe.
- R6: After the last chunk, command 0x10 is issued. No strobe follows until the ready/busy input has been seen low and then high.
- R7: After ready returns, command 0x70 is issued, then one read strobe. On the next cycle done pulses for one cycle, and pass is 1 only when status bit 7 is 1 and bit 0 is 0.
- R8: In copy mode the sequence starts with 0x00, a full address with column 0 and the source row, then 0x35. The block waits for busy-then-ready, then sends 0x85 and a full address with column 0 and the destination row before the chunks. With zero chunks it proceeds directly to 0x10.
- R9: Busy rises on the cycle after an accepted start and falls with done. Chip enable is high on every strobe cycle and low once done is seen. A start while busy is ignored, as is a program-mode start with zero chunks.
- R10: While the data queue is empty during a chunk's data phase, no strobe is issued. The sequence resumes unchanged once bytes are pushed, including a push and a pop in the same cycle.
- R11: At most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| copy_mode | input | 1 | 1 selects the copy sequence |
| num_chunks | input | NCH_W | Number of chunks in the operation |
| row_addr | input | ROW_W | Row of the page to program (destination) |
| src_row | input | ROW_W | Source row for copy mode |
| desc_push | input | 1 | Push one chunk descriptor |
| desc_col | input | COL_W | Chunk column offset |
| desc_spare | input | 1 | Chunk targets the spare area |
| desc_len | input | LEN_W | Chunk length in bytes |
| data_push | input | 1 | Push one data byte |
| data_in | input | 8 | Data byte |
| nand_rb | input | 1 | Ready (1) / busy (0) from the device |
| nand_dq_in | input | 8 | Byte returned by the device on a read strobe |
| nand_ce | output | 1 | Chip enable, active high |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we | output | 1 | Data write strobe |
| nand_re | output | 1 | Data read strobe |
| nand_dq_out | output | 8 | Byte for the current strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last operation |

## Verification
Two cases can fall on the same clock. In the first, a new start arrives while an operation is running. In the second, a data byte is pushed on the same cycle the sequencer pops one for a write strobe. The bench sends a second start with different parameters a few cycles into a run. It also withholds part of the data until the data phase has stalled and then trickles it in. A per-clock reference queue of expected strobes must match exactly, with no extra or missing strobe, in both cases.

// File: rtl/nps_pkg.sv
package nps_pkg;
  localparam logic [7:0] OP_PAGE_RD   = 8'h00;
  localparam logic [7:0] OP_LOAD      = 8'h80;
  localparam logic [7:0] OP_RAND_IN   = 8'h85;
  localparam logic [7:0] OP_COPY_RD   = 8'h35;
  localparam logic [7:0] OP_CONFIRM   = 8'h10;
  localparam logic [7:0] OP_STATUS    = 8'h70;

  typedef enum logic [4:0] {
    ST_IDLE, ST_SRC_CMD, ST_SRC_ADR, ST_SRC_CNF, ST_SRC_BSY, ST_SRC_RDY,
    ST_DST_CMD, ST_DST_ADR, ST_CHK_CMD, ST_CHK_ADR, ST_DATA,
    ST_PRG_CMD, ST_PRG_BSY, ST_PRG_RDY, ST_STA_CMD, ST_STA_RD, ST_CAPT
  } seq_state_t;
endpackage

// File: rtl/nps_fifo.sv
module nps_fifo #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic do_push, do_pop;

  assign do_push = push && (cnt != (AW+1)'(DEPTH));
  assign do_pop  = pop && (cnt != '0);
  assign empty   = (cnt == '0);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/nps_ctrl.sv
module nps_ctrl
  import nps_pkg::*;
#(
  parameter int NCH_W     = 4,
  parameter int COL_W     = 12,
  parameter int ROW_W     = 24,
  parameter int LEN_W     = 15,
  parameter int PAGE_MAIN = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             copy_mode,
  input  logic [NCH_W-1:0] num_chunks,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [ROW_W-1:0] src_row,
  input  logic             desc_valid,
  input  logic [COL_W-1:0] desc_col,
  input  logic             desc_spare,
  input  logic [LEN_W-1:0] desc_len,
  output logic             desc_pop,
  input  logic             data_valid,
  input  logic [7:0]       data_word,
  output logic             data_pop,
  input  logic             rb,
  input  logic [7:0]       dq_in,
  output logic             ce,
  output logic             cle,
  output logic             ale,
  output logic             we,
  output logic             re,
  output logic [7:0]       dq_out,
  output logic             busy,
  output logic             done,
  output logic             pass
);
  localparam int ROW_BYTES = (ROW_W + 7) / 8;
  localparam int FULL_CYC  = 2 + ROW_BYTES;
  localparam int CNT_W     = $clog2(FULL_CYC + 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(FULL_CYC - 1);
  localparam logic [CNT_W-1:0] COL_LAST  = CNT_W'(1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [NCH_W-1:0] chunks_left;
  logic             first, copy_q;
  logic [ROW_W-1:0] row_q, src_q;
  logic [15:0]      col_q;
  logic [LEN_W-1:0] len_q;

  function automatic logic [7:0] addr_byte(input logic [CNT_W-1:0] idx,
                                           input logic [15:0] col,
                                           input logic [ROW_W-1:0] row);
    logic [8*ROW_BYTES-1:0] rp;
    int sel;
    rp  = (8*ROW_BYTES)'(row);
    sel = int'(idx);
    if (sel == 0)      return col[7:0];
    else if (sel == 1) return col[15:8];
    else               return rp[(sel-2)*8 +: 8];
  endfunction

  assign desc_pop = (state == ST_CHK_CMD) && desc_valid;
  assign data_pop = (state == ST_DATA) && data_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; cnt <= '0; chunks_left <= '0; first <= 1'b0; copy_q <= 1'b0;
      row_q <= '0; src_q <= '0; col_q <= '0; len_q <= '0;
      ce <= 1'b0; cle <= 1'b0; ale <= 1'b0; we <= 1'b0; re <= 1'b0; dq_out <= '0;
      busy <= 1'b0; done <= 1'b0; pass <= 1'b0;
    end else begin
      cle <= 1'b0; ale <= 1'b0; we <= 1'b0; re <= 1'b0; done <= 1'b0;
      case (state)
        ST_IDLE: if (start && (copy_mode || num_chunks != '0)) begin
          busy <= 1'b1; copy_q <= copy_mode; chunks_left <= num_chunks;
          row_q <= row_addr; src_q <= src_row; first <= 1'b1;
          state <= copy_mode ? ST_SRC_CMD : ST_CHK_CMD;
        end
        ST_SRC_CMD: begin
          ce <= 1'b1; cle <= 1'b1; dq_out <= OP_PAGE_RD; cnt <= '0; state <= ST_SRC_ADR;
        end
        ST_SRC_ADR: begin
          ale <= 1'b1; dq_out <= addr_byte(cnt, 16'h0000, src_q);
          if (cnt == FULL_LAST) state <= ST_SRC_CNF;
          else cnt <= cnt + 1'b1;
        end
        ST_SRC_CNF: begin cle <= 1'b1; dq_out <= OP_COPY_RD; state <= ST_SRC_BSY; end
        ST_SRC_BSY: if (!rb) state <= ST_SRC_RDY;
        ST_SRC_RDY: if (rb) state <= ST_DST_CMD;
        ST_DST_CMD: begin
          cle <= 1'b1; dq_out <= OP_RAND_IN; cnt <= '0; state <= ST_DST_ADR;
        end
        ST_DST_ADR: begin
          ale <= 1'b1; dq_out <= addr_byte(cnt, 16'h0000, row_q);
          if (cnt == FULL_LAST) begin
            first <= 1'b0;
            state <= (chunks_left == '0) ? ST_PRG_CMD : ST_CHK_CMD;
          end else cnt <= cnt + 1'b1;
        end
        ST_CHK_CMD: if (desc_valid) begin
          ce <= 1'b1; cle <= 1'b1;
          dq_out <= (first && !copy_q) ? OP_LOAD : OP_RAND_IN;
          col_q  <= desc_spare ? (16'(PAGE_MAIN) + 16'(desc_col)) : 16'(desc_col);
          len_q  <= desc_len; cnt <= '0; state <= ST_CHK_ADR;
        end
        ST_CHK_ADR: begin
          ale <= 1'b1; dq_out <= addr_byte(cnt, col_q, row_q);
          if (cnt == (first ? FULL_LAST : COL_LAST)) begin
            first <= 1'b0;
            chunks_left <= chunks_left - 1'b1;
            if (len_q != '0) state <= ST_DATA;
            else if (chunks_left == NCH_W'(1)) state <= ST_PRG_CMD;
            else state <= ST_CHK_CMD;
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: if (data_valid) begin
          we <= 1'b1; dq_out <= data_word; len_q <= len_q - 1'b1;
          if (len_q == LEN_W'(1)) state <= (chunks_left == '0) ? ST_PRG_CMD : ST_CHK_CMD;
        end
        ST_PRG_CMD: begin cle <= 1'b1; dq_out <= OP_CONFIRM; state <= ST_PRG_BSY; end
        ST_PRG_BSY: if (!rb) state <= ST_PRG_RDY;
        ST_PRG_RDY: if (rb) state <= ST_STA_CMD;
        ST_STA_CMD: begin cle <= 1'b1; dq_out <= OP_STATUS; state <= ST_STA_RD; end
        ST_STA_RD:  begin re <= 1'b1; state <= ST_CAPT; end
        ST_CAPT: begin
          pass <= dq_in[7] & ~dq_in[0];
          done <= 1'b1; busy <= 1'b0; ce <= 1'b0; state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({cle, ale, we, re}));
  // R9
  strobe_ce_chk: assert property (@(posedge clk) disable iff (rst) (cle | ale | we | re) |-> ce);
  // R9
  ce_after_busy_chk: assert property (@(posedge clk) disable iff (rst) $rose(ce) |-> $past(busy));
  // R6
  confirm_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cle && dq_out == OP_CONFIRM) |=> !(cle | ale | we | re));
  // R7
  done_after_read_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(re));
endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq #(
  parameter int NCH_W     = 4,
  parameter int COL_W     = 12,
  parameter int ROW_W     = 24,
  parameter int LEN_W     = 15,
  parameter int PAGE_MAIN = 2048,
  parameter int DATA_AW   = 6,
  parameter int DESC_AW   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             copy_mode,
  input  logic [NCH_W-1:0] num_chunks,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [ROW_W-1:0] src_row,
  input  logic             desc_push,
  input  logic [COL_W-1:0] desc_col,
  input  logic             desc_spare,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             data_push,
  input  logic [7:0]       data_in,
  input  logic             nand_rb,
  input  logic [7:0]       nand_dq_in,
  output logic             nand_ce,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we,
  output logic             nand_re,
  output logic [7:0]       nand_dq_out,
  output logic             busy,
  output logic             done,
  output logic             pass
);
  localparam int DESC_W = COL_W + 1 + LEN_W;

  logic [DESC_W-1:0] desc_q;
  logic desc_empty, desc_pop;
  logic [7:0] data_q;
  logic data_empty, data_pop;

  nps_fifo #(.W(DESC_W), .AW(DESC_AW)) u_desc (
    .clk(clk), .rst(rst), .push(desc_push), .din({desc_col, desc_spare, desc_len}),
    .pop(desc_pop), .dout(desc_q), .empty(desc_empty));

  nps_fifo #(.W(8), .AW(DATA_AW)) u_data (
    .clk(clk), .rst(rst), .push(data_push), .din(data_in),
    .pop(data_pop), .dout(data_q), .empty(data_empty));

  nps_ctrl #(.NCH_W(NCH_W), .COL_W(COL_W), .ROW_W(ROW_W), .LEN_W(LEN_W),
             .PAGE_MAIN(PAGE_MAIN)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .copy_mode(copy_mode),
    .num_chunks(num_chunks), .row_addr(row_addr), .src_row(src_row),
    .desc_valid(!desc_empty), .desc_col(desc_q[DESC_W-1 -: COL_W]),
    .desc_spare(desc_q[LEN_W]), .desc_len(desc_q[LEN_W-1:0]), .desc_pop(desc_pop),
    .data_valid(!data_empty), .data_word(data_q), .data_pop(data_pop),
    .rb(nand_rb), .dq_in(nand_dq_in),
    .ce(nand_ce), .cle(nand_cle), .ale(nand_ale), .we(nand_we), .re(nand_re),
    .dq_out(nand_dq_out), .busy(busy), .done(done), .pass(pass));
endmodule

// File: tb/nand_prog_seq_test.sv
module nand_prog_seq_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic start = 0, copy_mode = 0, desc_push = 0, desc_spare = 0, data_push = 0;
  logic [3:0]  num_chunks = '0;
  logic [23:0] row_addr = '0, src_row = '0;
  logic [11:0] desc_col = '0;
  logic [14:0] desc_len = '0;
  logic [7:0]  data_in = '0, stat_byte = '0;
  logic        rb;
  logic nand_ce, nand_cle, nand_ale, nand_we, nand_re, busy, done, pass;
  logic [7:0] nand_dq_out;

  nand_prog_seq uut (
    .clk(clk), .rst(rst), .start(start), .copy_mode(copy_mode), .num_chunks(num_chunks),
    .row_addr(row_addr), .src_row(src_row), .desc_push(desc_push), .desc_col(desc_col),
    .desc_spare(desc_spare), .desc_len(desc_len), .data_push(data_push), .data_in(data_in),
    .nand_rb(rb), .nand_dq_in(stat_byte), .nand_ce(nand_ce), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we(nand_we), .nand_re(nand_re), .nand_dq_out(nand_dq_out),
    .busy(busy), .done(done), .pass(pass));

  int checks = 0, fails = 0, rb_cnt = 0;
  logic [11:0] exp_ev[$];
  string       exp_rq[$];
  logic [11:0] ccol[4];
  logic        csp[4];
  int          clen[4];

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // reference model: expected strobe stream, compared on every clock
  always @(negedge clk) begin
    logic [11:0] ev, e;
    string r;
    if (rst) begin
      rb = 1'b1; rb_cnt = 0;
    end else begin
      if (nand_cle | nand_ale | nand_we | nand_re) begin
        check($onehot0({nand_cle, nand_ale, nand_we, nand_re}), "R11", "strobe count",
              int'({nand_cle, nand_ale, nand_we, nand_re}), 1);
        check(nand_ce, "R9", "ce on strobe", int'(nand_ce), 1);
        check(rb, "R6", "strobe while device busy", int'(rb), 1);
        ev = {nand_cle, nand_ale, nand_we, nand_re, nand_re ? 8'h00 : nand_dq_out};
        if (exp_ev.size() == 0) check(0, "R9", "unexpected strobe", int'(ev), 0);
        else begin
          e = exp_ev.pop_front(); r = exp_rq.pop_front();
          check(ev == e, r, "bus event", int'(ev), int'(e));
        end
      end
      if (rb_cnt > 0) begin rb_cnt--; if (rb_cnt == 0) rb = 1'b1; end
      if (nand_cle && (nand_dq_out == 8'h10 || nand_dq_out == 8'h35)) begin
        rb = 1'b0; rb_cnt = 4;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic ex(input logic [3:0] k, input logic [7:0] b, input string rq);
    exp_ev.push_back({k, b}); exp_rq.push_back(rq);
  endtask

  task automatic ex_full(input logic [15:0] col, input logic [23:0] row, input string rq);
    ex(4'b0100, col[7:0], rq);  ex(4'b0100, col[15:8], rq);
    ex(4'b0100, row[7:0], rq);  ex(4'b0100, row[15:8], rq); ex(4'b0100, row[23:16], rq);
  endtask

  task automatic run_seq(input int n, input bit cp, input logic [23:0] dst,
                         input logic [23:0] src, input logic [7:0] st, input int pre,
                         input bit poke);
    logic [7:0] words[$];
    logic [15:0] c16;
    string drq;
    int t;
    drq = (pre >= 0) ? "R10" : "R5";
    stat_byte = st;
    if (cp) begin
      ex(4'b1000, 8'h00, "R8"); ex_full(16'h0, src, "R8"); ex(4'b1000, 8'h35, "R8");
      ex(4'b1000, 8'h85, "R8"); ex_full(16'h0, dst, "R8");
    end
    for (int i = 0; i < n; i++) begin
      c16 = csp[i] ? 16'(2048 + int'(ccol[i])) : 16'(ccol[i]);
      if (!cp && i == 0) begin
        ex(4'b1000, 8'h80, "R2"); ex_full(c16, dst, csp[i] ? "R3" : "R2");
      end else begin
        ex(4'b1000, 8'h85, "R4");
        ex(4'b0100, c16[7:0], csp[i] ? "R3" : "R4"); ex(4'b0100, c16[15:8], "R4");
      end
      for (int k = 0; k < clen[i]; k++) begin
        words.push_back(8'(i*37 + k*5 + 1));
        ex(4'b0010, 8'(i*37 + k*5 + 1), drq);
      end
    end
    ex(4'b1000, 8'h10, "R6"); ex(4'b1000, 8'h70, "R7"); ex(4'b0001, 8'h00, "R7");
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      desc_push = 1; desc_col = ccol[i]; desc_spare = csp[i]; desc_len = 15'(clen[i]);
      @(negedge clk);
    end
    desc_push = 0;
    t = (pre < 0) ? words.size() : pre;
    for (int i = 0; i < t; i++) begin
      data_push = 1; data_in = words.pop_front(); @(negedge clk);
    end
    data_push = 0;
    copy_mode = cp; num_chunks = 4'(n); row_addr = dst; src_row = src; start = 1;
    @(negedge clk); start = 0;
    check(busy, "R9", "busy after start", int'(busy), 1);
    if (poke) begin
      repeat (2) @(negedge clk);
      check(busy, "R9", "busy before second start", int'(busy), 1);
      copy_mode = 1; num_chunks = 4'd1; row_addr = 24'hFFFFFF; start = 1;
      @(negedge clk); start = 0;
    end
    if (words.size() > 0) begin
      repeat (12) @(negedge clk);
      while (words.size() > 0) begin
        data_push = 1; data_in = words.pop_front(); @(negedge clk);
      end
      data_push = 0;
    end
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    check(done, "R7", "done seen", int'(done), 1);
    check(pass == (st[7] & ~st[0]), "R7", "pass result", int'(pass), int'(st[7] & ~st[0]));
    check(!nand_ce, "R9", "ce low at done", int'(nand_ce), 0);
    check(!busy, "R9", "busy low at done", int'(busy), 0);
    check(exp_ev.size() == 0, "R5", "events left over", exp_ev.size(), 0);
    @(negedge clk);
    check(!done, "R7", "done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check({nand_ce, nand_cle, nand_ale, nand_we, nand_re, busy, done} == 7'b0, "R1",
          "reset outputs", int'({nand_ce, nand_cle, nand_ale, nand_we, nand_re, busy, done}), 0);

    // R2 R3 R5: main then spare chunk, pass status
    ccol[0] = 12'h005; csp[0] = 0; clen[0] = 3;
    ccol[1] = 12'h002; csp[1] = 1; clen[1] = 2;
    run_seq(2, 0, 24'h123456, 24'h0, 8'hE0, -1, 0);

    // R4 R5 R9: zero-length middle chunk, fail bit0, second start while busy
    ccol[0] = 12'h001; csp[0] = 1; clen[0] = 2;
    ccol[1] = 12'h010; csp[1] = 0; clen[1] = 0;
    ccol[2] = 12'h120; csp[2] = 0; clen[2] = 4;
    run_seq(3, 0, 24'hA1B2C3, 24'h0, 8'hC1, -1, 1);

    // R7 R10: protected status, data arrives only after the stall
    ccol[0] = 12'h7FF; csp[0] = 0; clen[0] = 1;
    run_seq(1, 0, 24'h000100, 24'h0, 8'h00, 0, 0);

    // R8: copy with two patches
    ccol[0] = 12'h008; csp[0] = 0; clen[0] = 2;
    ccol[1] = 12'h000; csp[1] = 1; clen[1] = 1;
    run_seq(2, 1, 24'h00A0B0, 24'h000A0B, 8'h80, -1, 0);

    // R8: copy with no patches
    run_seq(0, 1, 24'h0F0F0F, 24'h707070, 8'h81, -1, 0);

    // R10: partial data preload, rest pushed while popping
    ccol[0] = 12'h020; csp[0] = 0; clen[0] = 3;
    ccol[1] = 12'h030; csp[1] = 1; clen[1] = 3;
    run_seq(2, 0, 24'h55AA33, 24'h0, 8'hE0, 2, 0);

    // R9: program start with zero chunks is ignored
    copy_mode = 0; num_chunks = 4'd0; start = 1;
    @(negedge clk); start = 0;
    check(!busy, "R9", "zero-chunk start ignored", int'(busy), 0);
    repeat (5) @(negedge clk);
    check(!busy && !nand_ce, "R9", "still idle", int'({busy, nand_ce}), 0);

    finish_run();
  end
endmodule